// File: doc/BRIEF.md
# Per-Mask Outstanding Load Counter

This block sits next to a load/store pipeline and keeps one live counter for every combination of warp, destination register and lane mask that still has memory accesses in flight. When a load is issued, the pipeline reports how many accesses it split into. Every returning access is reported once. When the last access of a given tuple comes back, the block sends a release for that exact tuple to a scoreboard that tracks reservations by register and mask.

Counts are never merged across masks. Two co-issued instructions that write the same register with disjoint lanes each release their own reservation when their own accesses finish. Neither waits for the other. Storage is a small table that is searched on the full tuple. Tracking only happens while the mode input selects mask-aware operation.

Top module: `mask_load_tracker`

## Requirements
- R1: After reset, `rel_valid`, `full_stall` and `count_err` are all 0, and the table holds no entries.
- R2: An issue with nonzero `iss_reg` and nonzero `iss_count` adds `iss_count` to the counter of its (warp, register, mask) tuple. It creates the entry if none exists. Repeated issues to the same tuple add up.
- R3: Each completion subtracts one from the counter of its tuple. In the cycle after the completion that brings a counter to zero, `rel_valid` is high for exactly one cycle, with `rel_warp`, `rel_reg` and `rel_mask` equal to that tuple. Earlier completions of the same tuple produce no release.
- R4: Tuples that differ only in mask are counted independently. Each one is released when its own count drains, in whatever order that happens.
- R5: A completion whose tuple has no live entry changes no counter, produces no release and does not raise `count_err`.
- R6: An issue with `iss_reg` equal to 0 is not tracked. A later completion to register 0 produces no release.
- R7: While `mode_en` is 0, issues and completions change no counter, and `rel_valid`, `full_stall` and `count_err` stay 0. Live entries keep their counts until the mode returns.
- R8: An issue and a completion to the same tuple in the same cycle are both applied, giving a net change of `iss_count` minus one. This holds even when the tuple had no entry yet: a net of zero releases at once.
- R9: With all DEPTH entries live, an issue that needs a new entry raises `full_stall` combinationally in the same cycle and is dropped. An issue that matches a live entry is still accepted with `full_stall` low.
- R10: A completion in the same cycle as a zero-count issue to a tuple with no live entry is an underflow. `count_err` pulses for one cycle in the following cycle, and no release is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | 1 selects mask-aware tracking |
| iss_valid | input | 1 | Issue strobe |
| iss_warp | input | WARP_W | Issuing warp |
| iss_reg | input | REG_W | Destination register, 0 means none |
| iss_mask | input | MASK_W | Issue-time lane mask |
| iss_count | input | CNT_W | Number of memory accesses generated |
| cmp_valid | input | 1 | One access returned |
| cmp_warp | input | WARP_W | Warp of the returned access |
| cmp_reg | input | REG_W | Register of the returned access |
| cmp_mask | input | MASK_W | Lane mask of the returned access |
| rel_valid | output | 1 | Registered release strobe |
| rel_warp | output | WARP_W | Warp to release |
| rel_reg | output | REG_W | Register to release |
| rel_mask | output | MASK_W | Mask to release |
| full_stall | output | 1 | Issue refused, table full |
| count_err | output | 1 | Registered underflow pulse |

## Verification
A counter that is wrong inside the table shows up only when its tuple drains. If the count is too low, the release comes a completion early. If it is too high, the release never comes, and the scoreboard would stay blocked. The tests therefore check for a missing release at every intermediate completion and for the release one cycle after the final one. A wrong match between tuples shows up as the wrong tuple on the release port, or as a mask drained by another mask's completions. The mixed-mask tests expose this on the first completion that crosses over.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

  // How one table slot changes in a cycle
  typedef enum logic [1:0] {
    SLOT_KEEP  = 2'd0,
    SLOT_FILL  = 2'd1,
    SLOT_ADJ   = 2'd2,
    SLOT_DROP  = 2'd3
  } slot_op_e;

  function automatic logic [31:0] idx_bits(input int unsigned depth);
    return (depth < 2) ? 32'd1 : 32'($clog2(depth));
  endfunction

endpackage

// File: rtl/mlt_match.sv
module mlt_match #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 45,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [DEPTH-1:0][KEY_W-1:0] slot_key,
  input  logic [KEY_W-1:0]            probe,
  output logic [DEPTH-1:0]            hit_vec,
  output logic                        hit_any,
  output logic [IDX_W-1:0]            hit_idx
);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = slot_vld[g] && (slot_key[g] == probe);
    end
  endgenerate

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/mlt_freefind.sv
module mlt_freefind #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0] slot_vld,
  output logic [IDX_W-1:0] free_idx,
  output logic             all_used
);

  assign all_used = &slot_vld;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_vld[i]) free_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/mask_load_tracker.sv
module mask_load_tracker
  import mlt_pkg::*;
#(
  parameter int WARP_W = 5,
  parameter int REG_W  = 8,
  parameter int MASK_W = 32,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              iss_valid,
  input  logic [WARP_W-1:0] iss_warp,
  input  logic [REG_W-1:0]  iss_reg,
  input  logic [MASK_W-1:0] iss_mask,
  input  logic [CNT_W-1:0]  iss_count,
  input  logic              cmp_valid,
  input  logic [WARP_W-1:0] cmp_warp,
  input  logic [REG_W-1:0]  cmp_reg,
  input  logic [MASK_W-1:0] cmp_mask,
  output logic              rel_valid,
  output logic [WARP_W-1:0] rel_warp,
  output logic [REG_W-1:0]  rel_reg,
  output logic [MASK_W-1:0] rel_mask,
  output logic              full_stall,
  output logic              count_err
);

  localparam int IDX_W = int'(idx_bits(DEPTH));
  localparam int KEY_W = WARP_W + REG_W + MASK_W;
  localparam int SUM_W = CNT_W + 1;

  // Table state
  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [DEPTH-1:0][KEY_W-1:0] key_q, key_d;
  logic [DEPTH-1:0][CNT_W-1:0] cnt_q, cnt_d;

  logic [KEY_W-1:0] iss_key, cmp_key;
  assign iss_key = {iss_warp, iss_reg, iss_mask};
  assign cmp_key = {cmp_warp, cmp_reg, cmp_mask};

  logic iss_act, cmp_act, same_tuple;
  assign iss_act    = mode_en && iss_valid && (iss_reg != '0);
  assign cmp_act    = mode_en && cmp_valid;
  assign same_tuple = iss_act && cmp_act && (iss_key == cmp_key);

  logic [DEPTH-1:0] iss_hit, cmp_hit;
  logic             iss_any, cmp_any;
  logic [IDX_W-1:0] iss_idx, cmp_idx;
  logic [IDX_W-1:0] free_idx;
  logic             tbl_full;

  mlt_match #(.DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_iss_match (
    .slot_vld (vld_q),
    .slot_key (key_q),
    .probe    (iss_key),
    .hit_vec  (iss_hit),
    .hit_any  (iss_any),
    .hit_idx  (iss_idx)
  );

  mlt_match #(.DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_cmp_match (
    .slot_vld (vld_q),
    .slot_key (key_q),
    .probe    (cmp_key),
    .hit_vec  (cmp_hit),
    .hit_any  (cmp_any),
    .hit_idx  (cmp_idx)
  );

  mlt_freefind #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_free (
    .slot_vld (vld_q),
    .free_idx (free_idx),
    .all_used (tbl_full)
  );

  // Issue classification
  logic need_new, iss_ok, new_zero_net, alloc_go, underflow;
  assign need_new     = iss_act && !iss_any && (iss_count != '0);
  assign full_stall   = need_new && tbl_full;
  assign iss_ok       = iss_act && !full_stall;
  assign new_zero_net = need_new && same_tuple && (iss_count == CNT_W'(1));
  assign alloc_go     = need_new && !tbl_full && !new_zero_net;
  assign underflow    = same_tuple && !iss_any && (iss_count == '0);

  // Per-slot arithmetic
  logic [DEPTH-1:0][SUM_W-1:0] slot_sum;
  slot_op_e [DEPTH-1:0]        slot_op;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      logic [SUM_W-1:0] add_v, sub_v;
      assign add_v = (iss_ok && iss_hit[g]) ? SUM_W'(iss_count) : '0;
      assign sub_v = (cmp_act && cmp_hit[g]) ? SUM_W'(1) : '0;
      assign slot_sum[g] = SUM_W'(cnt_q[g]) + add_v - sub_v;
      always_comb begin
        if (alloc_go && (free_idx == IDX_W'(g)))
          slot_op[g] = SLOT_FILL;
        else if (!vld_q[g])
          slot_op[g] = SLOT_KEEP;
        else if (slot_sum[g] == '0)
          slot_op[g] = SLOT_DROP;
        else if ((add_v != '0) || (sub_v != '0))
          slot_op[g] = SLOT_ADJ;
        else
          slot_op[g] = SLOT_KEEP;
      end
    end
  endgenerate

  always_comb begin
    vld_d = vld_q;
    key_d = key_q;
    cnt_d = cnt_q;
    for (int i = 0; i < DEPTH; i++) begin
      unique case (slot_op[i])
        SLOT_FILL: begin
          vld_d[i] = 1'b1;
          key_d[i] = iss_key;
          cnt_d[i] = same_tuple ? (iss_count - CNT_W'(1)) : iss_count;
        end
        SLOT_ADJ:  cnt_d[i] = slot_sum[i][CNT_W-1:0];
        SLOT_DROP: vld_d[i] = 1'b0;
        default:   ;
      endcase
    end
  end

  // Zero detect: only a completion can drain a counter, so one per cycle
  logic drained;
  assign drained = (cmp_act && cmp_any && (slot_sum[cmp_idx] == '0)) ||
                   (new_zero_net && !tbl_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    key_q <= key_d;
    cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid <= 1'b0;
      rel_warp  <= '0;
      rel_reg   <= '0;
      rel_mask  <= '0;
      count_err <= 1'b0;
    end else begin
      rel_valid <= drained;
      count_err <= underflow;
      if (drained) begin
        rel_warp <= cmp_warp;
        rel_reg  <= cmp_reg;
        rel_mask <= cmp_mask;
      end
    end
  end

endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
  parameter int WARP_W = 5,
  parameter int REG_W  = 8,
  parameter int MASK_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_en,
  input logic              iss_valid,
  input logic [CNT_W-1:0]  iss_count,
  input logic              cmp_valid,
  input logic [WARP_W-1:0] cmp_warp,
  input logic [REG_W-1:0]  cmp_reg,
  input logic [MASK_W-1:0] cmp_mask,
  input logic              rel_valid,
  input logic [WARP_W-1:0] rel_warp,
  input logic [REG_W-1:0]  rel_reg,
  input logic [MASK_W-1:0] rel_mask,
  input logic              full_stall,
  input logic              count_err
);

  AST_REL_AFTER_CMP: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> $past(cmp_valid && mode_en)); // R3

  AST_REL_TUPLE: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (rel_warp == $past(cmp_warp)) && (rel_reg == $past(cmp_reg))
                  && (rel_mask == $past(cmp_mask))); // R3

  AST_REL_REG_NZ: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (rel_reg != '0)); // R6

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_en) |-> (!rel_valid && !count_err)); // R7

  AST_NO_STALL_OFF: assert property (@(posedge clk) disable iff (rst)
    !mode_en |-> !full_stall); // R7

  AST_STALL_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    full_stall |-> (iss_valid && (iss_count != '0))); // R9

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    count_err |-> (!rel_valid && $past(iss_valid && cmp_valid && (iss_count == '0)))); // R10

endmodule

bind mask_load_tracker mlt_checker #(
  .WARP_W(WARP_W), .REG_W(REG_W), .MASK_W(MASK_W), .CNT_W(CNT_W)
) u_mlt_checker (
  .clk(clk), .rst(rst), .mode_en(mode_en), .iss_valid(iss_valid),
  .iss_count(iss_count), .cmp_valid(cmp_valid), .cmp_warp(cmp_warp),
  .cmp_reg(cmp_reg), .cmp_mask(cmp_mask), .rel_valid(rel_valid),
  .rel_warp(rel_warp), .rel_reg(rel_reg), .rel_mask(rel_mask),
  .full_stall(full_stall), .count_err(count_err)
);

// File: tb/test_mask_load_tracker.sv
`timescale 1ns/1ps
module test_mask_load_tracker;

  localparam int WARP_W = 5;
  localparam int REG_W  = 8;
  localparam int MASK_W = 32;
  localparam int CNT_W  = 8;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b0;
  logic iss_valid = 1'b0;
  logic [WARP_W-1:0] iss_warp = '0;
  logic [REG_W-1:0]  iss_reg = '0;
  logic [MASK_W-1:0] iss_mask = '0;
  logic [CNT_W-1:0]  iss_count = '0;
  logic cmp_valid = 1'b0;
  logic [WARP_W-1:0] cmp_warp = '0;
  logic [REG_W-1:0]  cmp_reg = '0;
  logic [MASK_W-1:0] cmp_mask = '0;
  logic rel_valid, full_stall, count_err;
  logic [WARP_W-1:0] rel_warp;
  logic [REG_W-1:0]  rel_reg;
  logic [MASK_W-1:0] rel_mask;

  int checks = 0;
  int errors = 0;
  logic s_stall, s_rel, s_err;
  logic [WARP_W-1:0] s_rw;
  logic [REG_W-1:0]  s_rr;
  logic [MASK_W-1:0] s_rm;

  always #2 clk = ~clk;

  mask_load_tracker #(.WARP_W(WARP_W), .REG_W(REG_W), .MASK_W(MASK_W),
                      .CNT_W(CNT_W), .DEPTH(DEPTH)) i_mask_load_tracker (
    .clk(clk), .rst(rst), .mode_en(mode_en),
    .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_reg(iss_reg),
    .iss_mask(iss_mask), .iss_count(iss_count),
    .cmp_valid(cmp_valid), .cmp_warp(cmp_warp), .cmp_reg(cmp_reg),
    .cmp_mask(cmp_mask),
    .rel_valid(rel_valid), .rel_warp(rel_warp), .rel_reg(rel_reg),
    .rel_mask(rel_mask), .full_stall(full_stall), .count_err(count_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, capture stall before the edge,
  // capture registered outputs at the following negedge.
  task automatic step(input logic iv, input int iw, input int ir, input logic [MASK_W-1:0] im,
                      input int ic, input logic cv, input int cw, input int cr,
                      input logic [MASK_W-1:0] cm);
    iss_valid = iv; iss_warp = WARP_W'(iw); iss_reg = REG_W'(ir);
    iss_mask = im; iss_count = CNT_W'(ic);
    cmp_valid = cv; cmp_warp = WARP_W'(cw); cmp_reg = REG_W'(cr); cmp_mask = cm;
    #1 s_stall = full_stall;
    @(negedge clk);
    iss_valid = 1'b0; cmp_valid = 1'b0;
    s_rel = rel_valid; s_rw = rel_warp; s_rr = rel_reg; s_rm = rel_mask;
    s_err = count_err;
  endtask

  task automatic issue(input int w, input int r, input logic [MASK_W-1:0] m, input int c);
    step(1'b1, w, r, m, c, 1'b0, 0, 0, '0);
  endtask

  task automatic complete(input int w, input int r, input logic [MASK_W-1:0] m);
    step(1'b0, 0, 0, '0, 0, 1'b1, w, r, m);
  endtask

  task automatic expect_rel(input string req, input logic v, input int w, input int r,
                            input logic [MASK_W-1:0] m);
    check(req, 64'(s_rel), 64'(v));
    if (v) check(req, {WARP_W'(s_rw), REG_W'(s_rr), s_rm}, {WARP_W'(w), REG_W'(r), m});
  endtask

  localparam logic [MASK_W-1:0] MLO = 32'h0000_FFFF;
  localparam logic [MASK_W-1:0] MHI = 32'hFFFF_0000;

  task automatic t_reset();
    check("R1 rel_valid", 64'(rel_valid), 64'd0);
    check("R1 full_stall", 64'(full_stall), 64'd0);
    check("R1 count_err", 64'(count_err), 64'd0);
    complete(1, 5, MLO);
    expect_rel("R1 empty table", 1'b0, 0, 0, '0);
  endtask

  task automatic t_basic();
    issue(1, 5, MLO, 3);
    issue(1, 5, MLO, 1); // R2 coalesce: total 4
    for (int k = 0; k < 3; k++) begin
      complete(1, 5, MLO);
      expect_rel("R3 early", 1'b0, 0, 0, '0);
    end
    complete(1, 5, MLO);
    expect_rel("R3 final release", 1'b1, 1, 5, MLO);
    step(1'b0, 0, 0, '0, 0, 1'b0, 0, 0, '0);
    expect_rel("R3 one-cycle pulse", 1'b0, 0, 0, '0);
  endtask

  task automatic t_masks();
    issue(4, 9, MLO, 2);
    issue(4, 9, MHI, 1);
    complete(4, 9, MHI);
    expect_rel("R4 hi releases first", 1'b1, 4, 9, MHI);
    complete(4, 9, MLO);
    expect_rel("R4 lo still pending", 1'b0, 0, 0, '0);
    complete(4, 9, MLO);
    expect_rel("R4 lo release", 1'b1, 4, 9, MLO);
  endtask

  task automatic t_unmatched();
    issue(2, 3, MLO, 1);
    complete(2, 3, MHI);
    expect_rel("R5 no release", 1'b0, 0, 0, '0);
    check("R5 no err", 64'(s_err), 64'd0);
    complete(2, 3, MLO);
    expect_rel("R5 entry untouched", 1'b1, 2, 3, MLO);
  endtask

  task automatic t_reg0();
    issue(2, 0, MLO, 1);
    complete(2, 0, MLO);
    expect_rel("R6 reg0 untracked", 1'b0, 0, 0, '0);
  endtask

  task automatic t_mode();
    issue(3, 7, MHI, 1);
    mode_en = 1'b0;
    complete(3, 7, MHI);
    expect_rel("R7 off no release", 1'b0, 0, 0, '0);
    issue(3, 8, MHI, 1);
    check("R7 off no stall", 64'(s_stall), 64'd0);
    mode_en = 1'b1;
    complete(3, 8, MHI);
    expect_rel("R7 off issue not counted", 1'b0, 0, 0, '0);
    complete(3, 7, MHI);
    expect_rel("R7 count kept", 1'b1, 3, 7, MHI);
  endtask

  task automatic t_same_cycle();
    issue(5, 2, MLO, 1);
    step(1'b1, 5, 2, MLO, 2, 1'b1, 5, 2, MLO); // 1 + 2 - 1 = 2
    expect_rel("R8 net not zero", 1'b0, 0, 0, '0);
    complete(5, 2, MLO);
    expect_rel("R8 one left", 1'b0, 0, 0, '0);
    complete(5, 2, MLO);
    expect_rel("R8 drained", 1'b1, 5, 2, MLO);
    step(1'b1, 6, 4, MHI, 1, 1'b1, 6, 4, MHI); // new tuple, net 0
    expect_rel("R8 new tuple net zero", 1'b1, 6, 4, MHI);
    complete(6, 4, MHI);
    expect_rel("R8 nothing left", 1'b0, 0, 0, '0);
  endtask

  task automatic t_underflow();
    step(1'b1, 7, 1, MLO, 0, 1'b1, 7, 1, MLO);
    check("R10 err pulse", 64'(s_err), 64'd1);
    expect_rel("R10 no release", 1'b0, 0, 0, '0);
    step(1'b0, 0, 0, '0, 0, 1'b0, 0, 0, '0);
    check("R10 err one cycle", 64'(s_err), 64'd0);
  endtask

  task automatic t_full();
    for (int k = 1; k <= DEPTH; k++) begin
      issue(2, k, 32'h1, 1);
      check("R9 fill no stall", 64'(s_stall), 64'd0);
    end
    issue(2, 40, 32'h1, 1);
    check("R9 stall when full", 64'(s_stall), 64'd1);
    complete(2, 40, 32'h1);
    expect_rel("R9 stalled issue dropped", 1'b0, 0, 0, '0);
    issue(2, 3, 32'h1, 1);
    check("R9 hit accepted", 64'(s_stall), 64'd0);
    complete(2, 1, 32'h1);
    expect_rel("R9 free one", 1'b1, 2, 1, 32'h1);
    issue(2, 40, 32'h1, 1);
    check("R9 stall clears", 64'(s_stall), 64'd0);
    complete(2, 3, 32'h1);
    expect_rel("R9 hit counted", 1'b0, 0, 0, '0);
    complete(2, 3, 32'h1);
    expect_rel("R9 hit drained", 1'b1, 2, 3, 32'h1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mode_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_masks();
    t_unmatched();
    t_reg0();
    t_mode();
    t_same_cycle();
    t_underflow();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule